// File: doc/BRIEF.md
# Reloading PWM Timer with Event Counting

This block is an up-counter whose period is set by software. When the counter reaches its all-ones value and receives one more count, it restarts from a programmable reload value instead of zero. Each restart raises a sticky overflow flag. That flag can request an interrupt and gives the chip a periodic time base. Every channel compares the running count with its own compare register to produce a PWM waveform. The counter's range runs from the reload value to all-ones, and the compare value picks the duty cycle inside that range.

Counts arrive either from an internal tick, which fires once every `PRE_DIV` clocks, or from an external event pin. The external pin is synchronised and edge-detected. In external mode the block works as an event counter and raises the overflow flag after a number of events that depends on the reload value. Software reaches the control/status, reload, count and compare registers over a simple single-cycle register bus. A hardware count-enable input can gate counting in addition to the software run bit.

Top module: `artm_timer`

## Requirements
- R1: While counting, each count step takes the counter from v to v+1. A step taken at the all-ones value loads the reload value instead. For example, reload FDh gives the sequence FD, FE, FF, FD.
- R2: A count step taken at the all-ones value sets the overflow flag, which is bit 7 of the control/status register (address 0).
- R3: `irq_o` is high only while the overflow flag is set and the interrupt-enable bit (bit 2 of address 0) is 1. With that bit at 0, `irq_o` stays low even while the flag is set.
- R4: The overflow flag stays set until a read of address 0 with `bus_rd_i` high. That read returns the flag as 1 and clears it on the following edge. An overflow in the same cycle keeps the flag set.
- R5: In internal mode (bit 1 of address 0 is 0), the counter advances once every `PRE_DIV` clocks while it is enabled.
- R6: In external mode (bit 1 of address 0 is 1), each rising edge on `ev_i` advances the counter exactly once, three clocks after the edge is sampled. The overflow flag is set on the 256 minus reload-th event. Before that event the count reads FFh.
- R7: When the run bit (bit 0 of address 0) is 0 or `cnt_en_i` is low, the counter does not change. This includes external events.
- R8: A write to the reload register (address 1) while the run bit is 0 also loads the counter, so the count (read at address 2) equals the written value.
- R9: Each period, channel output `pwm_o[k]` is high for exactly (compare - reload) count states, or 0 if the compare value is at or below the reload value. A compare value of FFh holds the output high for the whole period. The compare register of channel k is at address 4+k.
- R10: While the counter runs, a compare write takes effect only at the next reload. The output does not change during the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (needed to clear the overflow flag) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data, combinational from the address |
| cnt_en_i | input | 1 | Hardware count enable |
| ev_i | input | 1 | External event/clock input, asynchronous |
| pwm_o | output | NUM_CH | PWM outputs, one per channel |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with `PRE_DIV` set to 2 and two channels. With those values a full 256-state period takes only 512 clocks, so a table of reload/compare pairs can cover the whole range, from the 0% and 100% cases to a 128-state period. The short prescale also shows the hold time of each count step directly in the sampled count sequence. The second channel is held at FFh throughout, which checks its full-period output against the first channel's swept compare.

// File: rtl/artm_pkg.sv
package artm_pkg;

    // Register addresses
    localparam int A_CTRL   = 0;
    localparam int A_RELOAD = 1;
    localparam int A_COUNT  = 2;
    localparam int A_CMP0   = 4;

    // Control/status bit positions
    localparam int RUN_BIT = 0;
    localparam int EXT_BIT = 1;
    localparam int IE_BIT  = 2;
    localparam int OVF_BIT = 7;

endpackage

// File: rtl/artm_prescale.sv
module artm_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        tick_o = en_i && (div_q == LAST);
        if (!en_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/artm_evsync.sv
module artm_evsync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ev_i,
    output logic pulse_o
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d    = {sh_q[1:0], ev_i};
        pulse_o = sh_q[1] & ~sh_q[2];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end
endmodule

// File: rtl/artm_pwm_chan.sv
module artm_pwm_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output logic [CNT_W-1:0] shadow_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
        logic             out;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (cmp_wr_i) begin
            ch_d.shadow = wdata_i;
        end
        if (load_i) begin
            ch_d.active = cmp_wr_i ? wdata_i : ch_q.shadow;
        end
        ch_d.out = (ch_d.active == TOP) || (cnt_next_i < ch_d.active);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign shadow_o = ch_q.shadow;
    assign pwm_o    = ch_q.out;
endmodule

// File: rtl/artm_timer.sv
module artm_timer
    import artm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_CH  = 2,
    parameter int PRE_DIV = 4,
    parameter int ADDR_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    input  logic              cnt_en_i,
    input  logic              ev_i,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              irq_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             ext_sel;
        logic             irq_en;
        logic             ovf;
    } tmr_t;

    tmr_t st_d, st_q;

    logic pre_tick, ev_pulse, tick, wrap;
    logic ctrl_wr, ctrl_rd, reload_wr;
    logic [CNT_W-1:0] cmp_shadow [NUM_CH];

    // Views of state for the bound checker
    logic [CNT_W-1:0] cnt_cur, reload_cur;
    logic             run_cur, ovf_cur, irq_en_cur;
    assign cnt_cur    = st_q.cnt;
    assign reload_cur = st_q.reload;
    assign run_cur    = st_q.run;
    assign ovf_cur    = st_q.ovf;
    assign irq_en_cur = st_q.irq_en;

    artm_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (st_q.run & cnt_en_i & ~st_q.ext_sel),
        .tick_o (pre_tick)
    );

    artm_evsync u_ev (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ev_i    (ev_i),
        .pulse_o (ev_pulse)
    );

    always_comb begin
        ctrl_wr   = bus_wr_i && (bus_addr_i == ADDR_W'(A_CTRL));
        ctrl_rd   = bus_rd_i && (bus_addr_i == ADDR_W'(A_CTRL));
        reload_wr = bus_wr_i && (bus_addr_i == ADDR_W'(A_RELOAD));
        tick      = st_q.run && cnt_en_i && (st_q.ext_sel ? ev_pulse : pre_tick);
        wrap      = tick && (st_q.cnt == TOP);

        st_d = st_q;
        if (ctrl_wr) begin
            st_d.run     = bus_wdata_i[RUN_BIT];
            st_d.ext_sel = bus_wdata_i[EXT_BIT];
            st_d.irq_en  = bus_wdata_i[IE_BIT];
        end
        if (reload_wr) begin
            st_d.reload = bus_wdata_i;
        end
        if (tick) begin
            st_d.cnt = wrap ? st_q.reload : st_q.cnt + 1'b1;
        end else if (reload_wr && !st_q.run) begin
            st_d.cnt = bus_wdata_i;
        end
        if (wrap) begin
            st_d.ovf = 1'b1;
        end else if (ctrl_rd) begin
            st_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        artm_pwm_chan #(.CNT_W(CNT_W)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cmp_wr_i   (bus_wr_i && (bus_addr_i == ADDR_W'(A_CMP0 + g))),
            .wdata_i    (bus_wdata_i),
            .load_i     (wrap || !st_q.run),
            .cnt_next_i (st_d.cnt),
            .shadow_o   (cmp_shadow[g]),
            .pwm_o      (pwm_o[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(A_CTRL)) begin
            bus_rdata_o[RUN_BIT] = st_q.run;
            bus_rdata_o[EXT_BIT] = st_q.ext_sel;
            bus_rdata_o[IE_BIT]  = st_q.irq_en;
            bus_rdata_o[OVF_BIT] = st_q.ovf;
        end else if (bus_addr_i == ADDR_W'(A_RELOAD)) begin
            bus_rdata_o = st_q.reload;
        end else if (bus_addr_i == ADDR_W'(A_COUNT)) begin
            bus_rdata_o = st_q.cnt;
        end else begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (bus_addr_i == ADDR_W'(A_CMP0 + k)) begin
                    bus_rdata_o = cmp_shadow[k];
                end
            end
        end
    end

    assign irq_o = st_q.ovf & st_q.irq_en;
endmodule

// File: rtl/artm_timer_chk.sv
module artm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick,
    input logic             ctrl_rd,
    input logic             reload_wr,
    input logic             run,
    input logic             ovf,
    input logic             irq_en,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] wdata
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_RELOAD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt == TOP) |=> (cnt == $past(reload))); // R1
    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1)); // R1
    AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && cnt == TOP) |=> ovf); // R2
    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en |-> !irq_o); // R3
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf && !ctrl_rd) |=> ovf); // R4
    AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf && ctrl_rd && !(tick && cnt == TOP)) |=> !ovf); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !reload_wr) |=> $stable(cnt)); // R7
    AST_IDLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && reload_wr) |=> (cnt == $past(wdata))); // R8
endmodule

bind artm_timer artm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick      (tick),
    .ctrl_rd   (ctrl_rd),
    .reload_wr (reload_wr),
    .run       (run_cur),
    .ovf       (ovf_cur),
    .irq_en    (irq_en_cur),
    .irq_o     (irq_o),
    .cnt       (cnt_cur),
    .reload    (reload_cur),
    .wdata     (bus_wdata_i)
);

// File: tb/test_artm_timer.sv
module test_artm_timer;
    localparam int CNT_W = 8;
    localparam int NUM_CH = 2;
    localparam int PRE = 2;
    localparam int ADDR_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0] wdata = '0;
    logic [CNT_W-1:0] rdata;
    logic cnt_en = 1'b1;
    logic ev = 1'b0;
    logic [NUM_CH-1:0] pwm;
    logic irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    artm_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .PRE_DIV(PRE), .ADDR_W(ADDR_W)) i_artm_timer (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .cnt_en_i(cnt_en), .ev_i(ev), .pwm_o(pwm), .irq_o(irq)
    );

    // reload, compare ch0, expected high states of ch0 per period
    localparam int NV = 7;
    localparam logic [7:0] VEC [NV][3] = '{
        '{8'hFD, 8'hFD, 8'd0},
        '{8'hFD, 8'hFE, 8'd1},
        '{8'hFD, 8'hFF, 8'd3},
        '{8'hF0, 8'hF8, 8'd8},
        '{8'h00, 8'h80, 8'd128},
        '{8'hC0, 8'hFF, 8'd64},
        '{8'h80, 8'h40, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        wr = 1'b1; addr = ADDR_W'(a); wdata = CNT_W'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        rd = 1'b1; addr = ADDR_W'(a);
        #1 d = int'(rdata);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic event_pulse();
        @(negedge clk); ev = 1'b1;
        repeat (3) @(negedge clk);
        ev = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_high(input int ch, input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm[ch]) hi++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int d, hi, n, prev, run_len, wraps, bad_step, bad_hold, cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_read(0, d); check("R2 reset ctrl", d, 0);
        bus_read(2, d); check("R1 reset count", d, 0);
        check("R3 reset irq", int'(irq), 0);
        check("R9 reset pwm", int'(pwm), 0);

        // Table: PWM high time over one period (R9)
        for (int v = 0; v < NV; v++) begin
            bus_write(0, 0);
            bus_write(1, VEC[v][0]);
            bus_write(4, VEC[v][1]);
            bus_write(5, 8'hFF);
            bus_write(0, 1);
            n = 256 - int'(VEC[v][0]);
            repeat (4) @(negedge clk);
            count_high(0, n * PRE, hi);
            check($sformatf("R9 ch0 reload=%0h cmp=%0h", VEC[v][0], VEC[v][1]), hi, int'(VEC[v][2]) * PRE);
            count_high(1, n * PRE, hi);
            check("R9 ch1 full duty", hi, n * PRE);
        end

        // R8 load while stopped, R1/R5 count sequence
        bus_write(0, 0);
        bus_write(1, 8'hFD);
        bus_read(2, d); check("R8 count loaded", d, 8'hFD);
        bus_write(0, 8'h05);
        @(negedge clk);
        addr = 3'd2;
        #1 prev = int'(rdata);
        run_len = 1; wraps = 0; bad_step = 0; bad_hold = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            #1 cur = int'(rdata);
            if (cur == prev) begin
                run_len++;
            end else begin
                if (cur != ((prev == 255) ? 8'hFD : prev + 1)) bad_step++;
                if (prev == 255) wraps++;
                if (i > 2 && run_len != PRE) bad_hold++;
                run_len = 1;
            end
            prev = cur;
        end
        check("R1 step sequence errors", bad_step, 0);
        check("R1 wraps seen", int'(wraps >= 2), 1);
        check("R5 hold length errors", bad_hold, 0);

        // R2/R3/R4
        check("R3 irq with enable", int'(irq), 1);
        bus_write(0, 8'h04);
        bus_read(0, d); check("R2 ovf flag read", (d >> 7) & 1, 1);
        bus_read(0, d); check("R4 ovf cleared by read", (d >> 7) & 1, 0);
        check("R4 irq after clear", int'(irq), 0);
        bus_write(0, 8'h01);
        repeat (20) @(negedge clk);
        check("R3 irq masked", int'(irq), 0);
        bus_write(0, 8'h00);
        repeat (3) @(negedge clk);
        check("R4 ovf sticky without read", int'(irq), 0);
        bus_read(0, d); check("R4 ovf held until read", (d >> 7) & 1, 1);

        // R7 gating
        bus_write(1, 8'hF0);
        bus_write(0, 8'h01);
        cnt_en = 1'b0;
        bus_read(2, prev);
        repeat (20) @(negedge clk);
        bus_read(2, d); check("R7 cnt_en low holds", d, prev);
        cnt_en = 1'b1;
        bus_write(0, 8'h00);
        bus_write(1, 8'hF8);
        bus_write(0, 8'h02);
        event_pulse(); event_pulse(); event_pulse();
        bus_read(2, d); check("R7 ext events while stopped", d, 8'hF8);

        // R6 event counting for several reloads
        foreach (VEC[i]) begin
            int r;
            if (i > 2) break;
            r = (i == 0) ? 8'hFD : (i == 1) ? 8'hF0 : 8'hFA;
            bus_write(0, 0);
            bus_write(1, r);
            bus_read(0, d);
            bus_write(0, 8'h03);
            n = 256 - r;
            for (int k = 0; k < n - 1; k++) event_pulse();
            bus_read(2, d); check($sformatf("R6 count before last event reload=%0h", r), d, 255);
            bus_read(0, d); check("R6 no ovf before last event", (d >> 7) & 1, 0);
            event_pulse();
            bus_read(0, d); check("R6 ovf after events", (d >> 7) & 1, 1);
            bus_read(2, d); check("R6 count reloaded", d, r);
        end

        // R10 buffered compare
        bus_write(0, 0);
        bus_write(1, 8'hF0);
        bus_write(4, 8'hF8);
        bus_write(0, 8'h01);
        addr = 3'd2;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            #1 if (rdata == 8'hF1) break;
        end
        bus_write(4, 8'hF0);
        check("R10 old compare still active", int'(pwm[0]), 1);
        repeat (40) @(negedge clk);
        count_high(0, 16 * PRE, hi);
        check("R10 new compare after reload", hi, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule